// File: doc/BRIEF.md
# Receive Frame Header/Payload Split Writer

This block sits between a MAC receive DMA and system memory. The DMA writes each received frame as a sequence of 32-bit words into one of two receive FIFO windows. The two windows differ only in address bit 16. The block then replays each frame to memory, starting at a destination address that software stored earlier in a per-descriptor address array. The DMA's register writes arrive on a separate register port, and frame data arrives only on the data port.

Frames are drained in strict descriptor order. Descriptor `i` is always taken from FIFO window `i mod 2`, and the descriptor index wraps at a programmable ring size. In split mode, the first 64 bytes of a frame go out on a cache-coherent write port and the rest go out on a bulk memory port at the base address plus 64. In full mode, the whole frame goes to the coherent port. Both output ports are simple valid/ready address-plus-data write channels. After the last word of each frame, a status register records the completed descriptor together with a sticky done bit.

Top module: `pkt_split_writer`

## Requirements
- R1: Destination address entry `i` sits at register offset 0x200 + 8*i. A write to it reads back unchanged at the same offset.
- R2: A data write goes to FIFO 1 when data address bit 16 is 1, and to FIFO 0 otherwise. Descriptor `i` drains only from FIFO `i mod 2`, so a frame waiting in the other FIFO is not emitted until its descriptor comes up.
- R3: In split mode, the first 16 words of a frame are emitted on the coherent port, starting at the descriptor's stored address.
- R4: In split mode, words from byte offset 64 onward are emitted on the bulk port, starting at stored address + 64.
- R5: A frame of 16 words or fewer produces no bulk-port beats.
- R6: Control register (offset 0x000) bit 0 set to 1 selects full mode, in which every word of the frame goes to the coherent port. The bit reads back as written.
- R7: Within a frame, each beat's address is the previous beat's address plus 4, and data words keep their arrival order.
- R8: When the FIFO addressed by a data write holds 512 words (the default depth), `dataReady` is low for that window and stays high for the other window. No word is lost.
- R9: While an output port has valid high and ready low, its address and data hold steady and no later word is emitted.
- R10: Descriptor indices run 0, 1, 2 … and wrap to 0 after the index held in control bits [13:8], which holds the ring size minus 1. After reset that field is 63 (RING_MAX − 1).
- R11: Status register (offset 0x004) bits [5:0] hold the last completed descriptor index, and bit 8 is a sticky done flag. Writing 1 to bit 8 clears the flag, and a completion in the same cycle takes priority.
- R12: An address-array write that lands after a frame's first beat has been accepted does not change that frame's addresses. It takes effect at the next use of that descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register byte offset for read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| dataValid | input | 1 | Frame data word valid |
| dataAddr | input | ADDR_W | Data write address; bit WIN_BIT picks the FIFO window |
| dataWord | input | 32 | Frame data word |
| dataLast | input | 1 | Marks the last word of a frame |
| dataReady | output | 1 | Addressed FIFO window can accept a word |
| cohValid | output | 1 | Coherent port beat valid |
| cohAddr | output | ADDR_W | Coherent port byte address |
| cohData | output | 32 | Coherent port write data |
| cohReady | input | 1 | Coherent port accepts the beat |
| bulkValid | output | 1 | Bulk port beat valid |
| bulkAddr | output | ADDR_W | Bulk port byte address |
| bulkData | output | 32 | Bulk port write data |
| bulkReady | input | 1 | Bulk port accepts the beat |

## Verification
The bench builds the block with a FIFO depth of 8 and a ring of 8 descriptors, and leaves the 64-byte header split at its default. With a shallow FIFO, a window fills after eight held-off words, so back-pressure on the data port and the stall hold on the coherent port can be exercised within a few cycles. With the small ring, the descriptor index wraps after a handful of frames, and reprogramming the ring to two entries lets the bench reuse a descriptor quickly to observe deferred address updates.

// File: rtl/psw_pkg.sv
package psw_pkg;
  // drain strobes from the sequencer to the datapath
  typedef struct packed {
    logic fifoSel;
    logic useBulk;
  } drainCmd_t;

  // per-beat handshake report from the datapath
  typedef struct packed {
    logic fire;
    logic last;
  } beatEvt_t;

  localparam int CTRL_OFS = 'h000;
  localparam int STAT_OFS = 'h004;
endpackage

// File: rtl/psw_fifo.sv
module psw_fifo #(
  parameter int WIDTH = 33,
  parameter int DEPTH = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/psw_datapath.sv
module psw_datapath
  import psw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 512,
  parameter int WIN_BIT    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataValid,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [31:0]       dataWord,
  input  logic              dataLast,
  output logic              dataReady,
  input  drainCmd_t         cmd,
  output beatEvt_t          evt,
  output logic [31:0]       headWord,
  output logic              cohValid,
  input  logic              cohReady,
  output logic              bulkValid,
  input  logic              bulkReady
);
  logic [32:0] headArr [2];
  logic [1:0]  fullVec, emptyVec, pushVec, popVec;
  logic        winSel, headValid;
  logic        unusedAddrBits;

  assign winSel         = dataAddr[WIN_BIT];
  assign unusedAddrBits = ^dataAddr;
  assign dataReady      = !fullVec[winSel];

  for (genvar g = 0; g < 2; g++) begin : gWin
    assign pushVec[g] = dataValid && dataReady && (winSel == 1'(g));
    assign popVec[g]  = evt.fire && (cmd.fifoSel == 1'(g));
    psw_fifo #(.WIDTH(33), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk    (clk),
      .rstN   (rstN),
      .push   (pushVec[g]),
      .pop    (popVec[g]),
      .wrData ({dataLast, dataWord}),
      .rdData (headArr[g]),
      .full   (fullVec[g]),
      .empty  (emptyVec[g])
    );
  end

  assign headValid = !emptyVec[cmd.fifoSel];
  assign headWord  = headArr[cmd.fifoSel][31:0];
  assign cohValid  = headValid && !cmd.useBulk;
  assign bulkValid = headValid && cmd.useBulk;
  assign evt.fire  = (cohValid && cohReady) || (bulkValid && bulkReady);
  assign evt.last  = headArr[cmd.fifoSel][32];
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int RING_MAX  = 64,
  parameter int HDR_BYTES = 64,
  parameter int REG_AW    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  beatEvt_t          evt,
  output drainCmd_t         cmd,
  output logic [ADDR_W-1:0] beatAddr
);
  localparam int IDX_W     = $clog2(RING_MAX);
  localparam int CNT_W     = 16;
  localparam int HDR_WORDS = HDR_BYTES / 4;

  logic [ADDR_W-1:0] addrArr [RING_MAX];
  logic [IDX_W-1:0]  descIdx, ringLast, doneIdx, arrIdx;
  logic [CNT_W-1:0]  wordCnt;
  logic [ADDR_W-1:0] heldBase, curBase;
  logic              fullMode, heldMode, curMode, doneFlag;
  logic              isCtrl, isStat, isArr;
  logic [5:0]        slot;

  // register decode: array slots at 0x200 + 8*i
  assign slot   = regAddr[8:3];
  assign arrIdx = slot[IDX_W-1:0];
  assign isCtrl = (regAddr == REG_AW'(CTRL_OFS));
  assign isStat = (regAddr == REG_AW'(STAT_OFS));
  assign isArr  = regAddr[9] && (regAddr[2:0] == 3'b000) && (int'(slot) < RING_MAX);

  always_ff @(posedge clk) begin
    if (regWe && isArr) addrArr[arrIdx] <= regWdata[ADDR_W-1:0];
  end

  always_comb begin
    regRdata = '0;
    if (isCtrl) begin
      regRdata[0]          = fullMode;
      regRdata[8 +: IDX_W] = ringLast;
    end else if (isStat) begin
      regRdata[IDX_W-1:0] = doneIdx;
      regRdata[8]         = doneFlag;
    end else if (isArr) begin
      regRdata[ADDR_W-1:0] = addrArr[arrIdx];
    end
  end

  // the first beat reads the live entry; later beats use the held copy
  assign curBase     = (wordCnt == '0) ? addrArr[descIdx] : heldBase;
  assign curMode     = (wordCnt == '0) ? fullMode : heldMode;
  assign cmd.fifoSel = descIdx[0];
  assign cmd.useBulk = !curMode && (wordCnt >= CNT_W'(HDR_WORDS));
  assign beatAddr    = curBase + ADDR_W'({wordCnt, 2'b00});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullMode <= 1'b0;
      ringLast <= IDX_W'(RING_MAX - 1);
      descIdx  <= '0;
      wordCnt  <= '0;
      heldBase <= '0;
      heldMode <= 1'b0;
      doneIdx  <= '0;
      doneFlag <= 1'b0;
    end else begin
      if (regWe && isCtrl) begin
        fullMode <= regWdata[0];
        ringLast <= regWdata[8 +: IDX_W];
      end
      if (regWe && isStat && regWdata[8]) doneFlag <= 1'b0;
      if (evt.fire) begin
        if (wordCnt == '0) begin
          heldBase <= curBase;
          heldMode <= curMode;
        end
        if (evt.last) begin
          wordCnt  <= '0;
          descIdx  <= (descIdx == ringLast) ? '0 : descIdx + IDX_W'(1);
          doneIdx  <= descIdx;
          doneFlag <= 1'b1;
        end else begin
          wordCnt <= wordCnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pkt_split_writer.sv
module pkt_split_writer
  import psw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 512,
  parameter int RING_MAX   = 64,
  parameter int HDR_BYTES  = 64,
  parameter int WIN_BIT    = 16,
  parameter int REG_AW     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              dataValid,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [31:0]       dataWord,
  input  logic              dataLast,
  output logic              dataReady,
  output logic              cohValid,
  output logic [ADDR_W-1:0] cohAddr,
  output logic [31:0]       cohData,
  input  logic              cohReady,
  output logic              bulkValid,
  output logic [ADDR_W-1:0] bulkAddr,
  output logic [31:0]       bulkData,
  input  logic              bulkReady
);
  drainCmd_t         cmd;
  beatEvt_t          evt;
  logic [31:0]       headWord;
  logic [ADDR_W-1:0] beatAddr;

  psw_ctrl #(
    .ADDR_W(ADDR_W), .RING_MAX(RING_MAX), .HDR_BYTES(HDR_BYTES), .REG_AW(REG_AW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evt(evt), .cmd(cmd),
    .beatAddr(beatAddr)
  );

  psw_datapath #(
    .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .WIN_BIT(WIN_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dataValid(dataValid), .dataAddr(dataAddr),
    .dataWord(dataWord), .dataLast(dataLast), .dataReady(dataReady),
    .cmd(cmd), .evt(evt), .headWord(headWord),
    .cohValid(cohValid), .cohReady(cohReady),
    .bulkValid(bulkValid), .bulkReady(bulkReady)
  );

  assign cohAddr  = beatAddr;
  assign bulkAddr = beatAddr;
  assign cohData  = headWord;
  assign bulkData = headWord;
endmodule

// File: rtl/psw_checker.sv
module psw_checker #(
  parameter int ADDR_W   = 32,
  parameter int RING_MAX = 64,
  parameter int REG_AW   = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic              cohValid,
  input logic [ADDR_W-1:0] cohAddr,
  input logic [31:0]       cohData,
  input logic              cohReady,
  input logic              bulkValid,
  input logic [ADDR_W-1:0] bulkAddr,
  input logic [31:0]       bulkData,
  input logic              bulkReady
);
  logic arrHit;
  assign arrHit = regAddr[9] && (regAddr[2:0] == 3'b000) && (int'(regAddr[8:3]) < RING_MAX);

  AST_COH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cohValid && !cohReady && !regWe) |=> (cohValid && $stable(cohAddr) && $stable(cohData))); // R9
  AST_BULK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (bulkValid && !bulkReady && !regWe) |=> (bulkValid && $stable(bulkAddr) && $stable(bulkData))); // R9
  AST_ARRAY_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && arrHit) |=> (!$stable(regAddr) || regRdata[ADDR_W-1:0] == $past(regWdata[ADDR_W-1:0]))); // R1
  AST_MODE_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == '0) |=> (!$stable(regAddr) || regRdata[0] == $past(regWdata[0]))); // R6
endmodule

bind pkt_split_writer psw_checker #(
  .ADDR_W(ADDR_W), .RING_MAX(RING_MAX), .REG_AW(REG_AW)
) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata),
  .cohValid(cohValid), .cohAddr(cohAddr), .cohData(cohData), .cohReady(cohReady),
  .bulkValid(bulkValid), .bulkAddr(bulkAddr), .bulkData(bulkData), .bulkReady(bulkReady)
);

// File: tb/test_pkt_split_writer.sv
module test_pkt_split_writer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int ARR = 'h200;

  logic clk = 0, rstN = 0;
  logic regWe = 0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic dataValid = 0, dataLast = 0, dataReady;
  logic [31:0] dataAddr = '0, dataWord = '0;
  logic cohValid, bulkValid, cohReady = 1, bulkReady = 1;
  logic [31:0] cohAddr, cohData, bulkAddr, bulkData;

  int nChk = 0, nErr = 0;
  logic [31:0] cohA [64], cohD [64], bulkA [64], bulkD [64];
  int cohN = 0, bulkN = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_split_writer #(.FIFO_DEPTH(8), .RING_MAX(8)) i_pkt_split_writer (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .dataValid(dataValid), .dataAddr(dataAddr), .dataWord(dataWord),
    .dataLast(dataLast), .dataReady(dataReady), .cohValid(cohValid), .cohAddr(cohAddr),
    .cohData(cohData), .cohReady(cohReady), .bulkValid(bulkValid), .bulkAddr(bulkAddr),
    .bulkData(bulkData), .bulkReady(bulkReady)
  );

  always @(negedge clk) if (rstN) begin
    if (cohValid && cohReady && cohN < 64) begin cohA[cohN] = cohAddr; cohD[cohN] = cohData; cohN++; end
    if (bulkValid && bulkReady && bulkN < 64) begin bulkA[bulkN] = bulkAddr; bulkD[bulkN] = bulkData; bulkN++; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input int a, input logic [31:0] d);
    @(posedge clk); #1 regWe = 1; regAddr = AW'(a); regWdata = d;
    @(posedge clk); #1 regWe = 0;
  endtask

  task automatic regRead(input int a, output logic [31:0] d);
    @(posedge clk); #1 regAddr = AW'(a); #2 d = regRdata;
  endtask

  task automatic pushWord(input int win, input logic [31:0] d, input logic last);
    logic ok;
    dataValid = 1; dataAddr = win ? 32'h0001_0000 : 32'h0; dataWord = d; dataLast = last;
    do begin @(negedge clk); ok = dataReady; @(posedge clk); end while (!ok);
    #1 dataValid = 0; dataLast = 0;
  endtask

  task automatic sendFrame(input int win, input int n, input logic [7:0] tag);
    for (int k = 0; k < n; k++) pushWord(win, {tag, 24'(k)}, k == n - 1);
  endtask

  task automatic waitIdle();
    repeat (40) @(posedge clk);
    #1;
  endtask

  task automatic clearLog();
    cohN = 0; bulkN = 0;
  endtask

  typedef struct packed {
    logic [31:0] base;
    logic [7:0]  words;
    logic        mode;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{base: 32'h1000, words: 8'd20, mode: 1'b0},
    '{base: 32'h2000, words: 8'd10, mode: 1'b0},
    '{base: 32'h3000, words: 8'd16, mode: 1'b0},
    '{base: 32'h4000, words: 8'd17, mode: 1'b1},
    '{base: 32'h5000, words: 8'd17, mode: 1'b0}
  };

  initial begin
    #(CLK_PERIOD * 100000);
    nErr++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;

    // reset state
    chk("reset cohValid", 32'(cohValid), 0);
    chk("reset bulkValid", 32'(bulkValid), 0);
    chk("R8 reset dataReady", 32'(dataReady), 1);
    regRead('h004, rd); chk("R11 reset status", rd, 0);
    regRead('h000, rd); chk("R10 reset ring field", rd, 32'h700);

    // vector table: one frame per descriptor 0..4
    for (int v = 0; v < 5; v++) begin
      int hw, bw;
      regWrite('h000, 32'h700 | 32'(VECS[v].mode));
      regWrite(ARR + 8 * v, VECS[v].base);
      clearLog();
      sendFrame(v % 2, int'(VECS[v].words), 8'(v));
      waitIdle();
      hw = VECS[v].mode ? int'(VECS[v].words) : (VECS[v].words > 16 ? 16 : int'(VECS[v].words));
      bw = int'(VECS[v].words) - hw;
      chk(VECS[v].mode ? "R6 full-mode coh count" : "R3 header coh count", 32'(cohN), 32'(hw));
      chk(bw == 0 ? "R5 no bulk beats" : "R4 bulk count", 32'(bulkN), 32'(bw));
      for (int k = 0; k < hw && k < cohN; k++) begin
        chk("R7 coh addr", cohA[k], VECS[v].base + 32'(4 * k));
        chk("R3 coh data", cohD[k], {8'(v), 24'(k)});
      end
      for (int k = 0; k < bw && k < bulkN; k++) begin
        chk("R4 bulk addr", bulkA[k], VECS[v].base + 32'd64 + 32'(4 * k));
        chk("R7 bulk data", bulkD[k], {8'(v), 24'(16 + k)});
      end
      regRead('h004, rd); chk("R11 status after frame", rd, 32'h100 | 32'(v));
    end

    // R11 write-1-to-clear
    regWrite('h004, 32'h100);
    regRead('h004, rd); chk("R11 done cleared", rd, 32'h004);

    // R2 window parity: descriptor 5 (window 1) blocks a frame waiting in window 0
    regWrite('h000, 32'h700);
    regWrite(ARR + 8 * 5, 32'h6000);
    regWrite(ARR + 8 * 6, 32'h7000);
    clearLog();
    sendFrame(0, 3, 8'h60);
    repeat (10) @(posedge clk); #1;
    chk("R2 other window waits", 32'(cohN), 0);
    sendFrame(1, 2, 8'h50);
    waitIdle();
    chk("R2 total beats", 32'(cohN), 5);
    chk("R2 first from window1", cohA[0], 32'h6000);
    chk("R2 first data", cohD[0], 32'h5000_0000);
    chk("R2 then window0", cohA[2], 32'h7000);
    chk("R2 window0 data", cohD[4], 32'h6000_0002);

    // R8 full FIFO and R9 stall hold: descriptor 7 on window 1
    regWrite(ARR + 8 * 7, 32'h8000);
    clearLog();
    cohReady = 0;
    for (int k = 0; k < 8; k++) pushWord(1, {8'h70, 24'(k)}, 1'b0);
    dataValid = 1; dataAddr = 32'h0001_0000; dataWord = {8'h70, 24'd8};
    @(negedge clk);
    chk("R8 full window held off", 32'(dataReady), 0);
    dataAddr = 32'h0; #1;
    chk("R8 other window ready", 32'(dataReady), 1);
    dataValid = 0;
    chk("R9 stalled valid", 32'(cohValid), 1);
    chk("R9 stalled addr", cohAddr, 32'h8000);
    repeat (3) @(negedge clk);
    chk("R9 addr held", cohAddr, 32'h8000);
    chk("R9 data held", cohData, 32'h7000_0000);
    chk("R9 nothing emitted", 32'(cohN), 0);
    @(posedge clk); #1 cohReady = 1;
    pushWord(1, {8'h70, 24'd8}, 1'b0);
    pushWord(1, {8'h70, 24'd9}, 1'b1);
    waitIdle();
    chk("R8 no word lost", 32'(cohN), 10);
    for (int k = 0; k < 10 && k < cohN; k++) begin
      chk("R9 order addr", cohA[k], 32'h8000 + 32'(4 * k));
      chk("R8 data kept", cohD[k], {8'h70, 24'(k)});
    end

    // R10 wrap at ring size 8 then at 2
    regWrite(ARR, 32'h9000);
    clearLog();
    sendFrame(0, 1, 8'h80);
    waitIdle();
    regRead('h004, rd); chk("R10 wrapped to 0", rd & 32'h3f, 0);
    chk("R10 wrapped base", cohA[0], 32'h9000);
    regWrite('h000, 32'h100);
    regWrite(ARR + 8, 32'hA000);
    sendFrame(1, 1, 8'h81);
    waitIdle();
    clearLog();
    sendFrame(0, 1, 8'h82);
    waitIdle();
    regRead('h004, rd); chk("R10 ring of two wraps", rd & 32'h3f, 0);
    chk("R10 ring of two base", cohA[0], 32'h9000);

    // R12 array write mid-frame, descriptor 1
    clearLog();
    pushWord(1, 32'h9000_0000, 1'b0);
    repeat (3) @(posedge clk); #1;
    regWrite(ARR + 8, 32'hB000);
    pushWord(1, 32'h9000_0001, 1'b0);
    pushWord(1, 32'h9000_0002, 1'b1);
    waitIdle();
    chk("R12 frame keeps base", cohA[1], 32'hA004);
    chk("R12 frame keeps base end", cohA[2], 32'hA008);
    sendFrame(0, 1, 8'h91);
    waitIdle();
    clearLog();
    sendFrame(1, 1, 8'h92);
    waitIdle();
    chk("R12 next use new base", cohA[0], 32'hB000);

    // R1 readback
    regWrite(ARR + 8 * 3, 32'h1234_5678);
    regRead(ARR + 8 * 3, rd); chk("R1 readback", rd, 32'h1234_5678);
    regRead(ARR + 8 * 6, rd); chk("R1 entry kept", rd, 32'h7000);
    regWrite('h000, 32'h701);
    regRead('h000, rd); chk("R6 mode readback", rd, 32'h701);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule